// File: doc/BRIEF.md
# Sampled Token Channel with Skip

This block carries a stream of data tokens from one producing node to one consuming node that tick at unrelated rates. Storage is a small ring of slots. The writer fills the slots in turn, one slot for each write strobe. The reader samples the slot it expects next. Each slot carries a one-bit toggle mark. The reader keeps its own expected mark for every slot, so it can tell a token it has not yet consumed from one it has already used. Neither side ever waits. When the expected slot holds nothing new, the reader reports a skip for that tick and does not react.

The channel is set by a slot count and a number of initial tokens. The initial tokens stand for logical delays between the two nodes. At reset they are placed in the first slots with a configurable value and marked as unconsumed. With back-pressure enabled, the channel raises a full flag once every slot holds an unread token, and writes made while that flag is up are dropped. With back-pressure disabled, the writer keeps moving round the ring and overwrites unread slots, and the newest data stays readable. A single clock serves both sides. Separate write and read strobes model the two nodes' independent activation instants.

Top module: `token_channel`

## Requirements
- R1: After reset the first INIT_TOKENS read ticks return INIT_VALUE with rd_valid high, one token per tick, and with no write made.
- R2: Tokens come out in the order they were written. rd_data and rd_valid are registered and appear in the cycle after the read strobe.
- R3: A read tick that finds no unconsumed token in the expected slot raises rd_skip with rd_valid low. The read position does not move, so a later write is still read.
- R4: A token written in cycle t is not visible to a read strobe in the same cycle t. A read strobe in cycle t+1 or later receives it.
- R5: Each read tick consumes at most one token. rd_valid and rd_skip are never high together, and both are low in the cycle after a cycle without a read strobe.
- R6: With BACKPRESSURE=1, wr_full is high exactly when all DEPTH slots hold unread tokens. A write strobe while wr_full is high is dropped, even when a read takes place in the same cycle, and its data never appears at rd_data.
- R7: With BACKPRESSURE=1, a read that consumes a token from a full ring clears wr_full in the following cycle.
- R8: With BACKPRESSURE=0, wr_full stays low. A write to a slot that still holds an unread token replaces its data and keeps it marked unread. The reader then gets the newest data of that slot, and the replaced token is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset; preloads the initial tokens |
| wr_en | input | 1 | Writer activation strobe |
| wr_data | input | DATA_W | Token presented by the writer |
| wr_full | output | 1 | All slots hold unread tokens (back-pressure only) |
| rd_en | input | 1 | Reader activation strobe |
| rd_data | output | DATA_W | Last token consumed |
| rd_valid | output | 1 | Previous read tick consumed a token |
| rd_skip | output | 1 | Previous read tick found no new token |

## Verification
The main instance is tried with reads that find only the preloaded token and reads that find an empty ring. The same-cycle write-and-read case tells apart a design that forwards a write combinationally from one that only reads registered slots. A burst of writes followed by reads separates FIFO order from LIFO or a stuck pointer. Filling the ring and then offering more writes, alone and together with a read, shows whether the full state is sampled, whether dropped data leaks out, and how fast the full flag clears. A second instance without back-pressure and without initial tokens is driven past one lap of the ring. This shows overwrite-in-place, the lost token, and the empty start.

// File: rtl/token_channel_pkg.sv
package token_channel_pkg;
  typedef enum logic [1:0] {
    RES_IDLE  = 2'd0,
    RES_TOKEN = 2'd1,
    RES_SKIP  = 2'd2
  } rd_result_e;
endpackage

// File: rtl/tkc_slot_ring.sv
module tkc_slot_ring #(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 4,
  parameter int PTR_W       = 2,
  parameter int INIT_TOKENS = 1,
  parameter logic [DATA_W-1:0] INIT_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_do,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DEPTH-1:0]  exp_after,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DEPTH-1:0]  tog_vec
);
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= (i < INIT_TOKENS) ? INIT_VALUE : '0;
        tog_q[i]  <= (i < INIT_TOKENS);
      end
    end else if (wr_do) begin
      data_q[wr_ptr] <= wr_data;
      // mark unread relative to the reader's mark after this cycle
      tog_q[wr_ptr]  <= ~exp_after[wr_ptr];
    end
  end

  assign rd_word = data_q[rd_ptr];
  assign tog_vec = tog_q;
endmodule

// File: rtl/tkc_writer.sv
module tkc_writer #(
  parameter int DEPTH        = 4,
  parameter int PTR_W        = 2,
  parameter int INIT_TOKENS  = 1,
  parameter bit BACKPRESSURE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DEPTH-1:0] tog_vec,
  input  logic [DEPTH-1:0] exp_vec,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wr_do,
  output logic             wr_full
);
  localparam int START = INIT_TOKENS % DEPTH;
  logic [PTR_W-1:0] ptr_q;
  logic             unread_here;

  assign unread_here = tog_vec[ptr_q] ^ exp_vec[ptr_q];

  generate
    if (BACKPRESSURE) begin : g_bp
      assign wr_full = unread_here;
    end else begin : g_nbp
      assign wr_full = 1'b0;
    end
  endgenerate

  assign wr_do = wr_en & ~wr_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= PTR_W'(START);
    end else if (wr_do) begin
      ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign wr_ptr = ptr_q;
endmodule

// File: rtl/tkc_reader.sv
module tkc_reader
  import token_channel_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [DEPTH-1:0]  tog_vec,
  input  logic [DATA_W-1:0] rd_word,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [DEPTH-1:0]  exp_vec,
  output logic              take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_skip
);
  logic [PTR_W-1:0]  ptr_q;
  logic [DEPTH-1:0]  exp_q;
  logic [DATA_W-1:0] data_q;
  rd_result_e        res_q;
  logic              fresh;

  assign fresh = tog_vec[ptr_q] ^ exp_q[ptr_q];
  assign take  = rd_en & fresh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      exp_q  <= '0;
      data_q <= '0;
      res_q  <= RES_IDLE;
    end else begin
      if (take) begin
        exp_q[ptr_q] <= ~exp_q[ptr_q];
        ptr_q  <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        data_q <= rd_word;
      end
      if (!rd_en)     res_q <= RES_IDLE;
      else if (fresh) res_q <= RES_TOKEN;
      else            res_q <= RES_SKIP;
    end
  end

  assign rd_ptr   = ptr_q;
  assign exp_vec  = exp_q;
  assign rd_data  = data_q;
  assign rd_valid = (res_q == RES_TOKEN);
  assign rd_skip  = (res_q == RES_SKIP);
endmodule

// File: rtl/token_channel.sv
module token_channel #(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 4,
  parameter int INIT_TOKENS  = 1,
  parameter logic [DATA_W-1:0] INIT_VALUE = 16'hA5A5,
  parameter bit BACKPRESSURE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_skip
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [DEPTH-1:0]  tog_vec, exp_vec, exp_after;
  logic [DATA_W-1:0] rd_word;
  logic              wr_do, take;

  assign exp_after = exp_vec ^ (take ? (DEPTH'(1) << rd_ptr) : '0);

  tkc_slot_ring #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W),
    .INIT_TOKENS(INIT_TOKENS), .INIT_VALUE(INIT_VALUE)
  ) u_ring (
    .clk(clk), .rst(rst), .wr_do(wr_do), .wr_ptr(wr_ptr),
    .wr_data(wr_data), .exp_after(exp_after), .rd_ptr(rd_ptr),
    .rd_word(rd_word), .tog_vec(tog_vec)
  );

  tkc_writer #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .INIT_TOKENS(INIT_TOKENS),
    .BACKPRESSURE(BACKPRESSURE)
  ) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .tog_vec(tog_vec),
    .exp_vec(exp_vec), .wr_ptr(wr_ptr), .wr_do(wr_do), .wr_full(wr_full)
  );

  tkc_reader #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .tog_vec(tog_vec),
    .rd_word(rd_word), .rd_ptr(rd_ptr), .exp_vec(exp_vec), .take(take),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_skip(rd_skip)
  );
endmodule

// File: rtl/token_channel_checker.sv
module token_channel_checker #(
  parameter int PTR_W        = 2,
  parameter int DEPTH        = 4,
  parameter bit BACKPRESSURE = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_full,
  input logic             rd_en,
  input logic             rd_valid,
  input logic             rd_skip,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr
);
  AST_VALID_SKIP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_skip)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && !rd_skip)); // R5

  AST_SKIP_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_skip == (rd_ptr == $past(rd_ptr)))); // R3

  AST_NO_OVERWRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    (BACKPRESSURE && wr_full && wr_en) |=> $stable(wr_ptr)); // R6

  AST_NBP_NEVER_FULL: assert property (@(posedge clk) disable iff (rst)
    !BACKPRESSURE |-> !wr_full); // R8
endmodule

bind token_channel token_channel_checker #(
  .PTR_W(PTR_W), .DEPTH(DEPTH), .BACKPRESSURE(BACKPRESSURE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_skip(rd_skip), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/tb_token_channel.sv
module tb_token_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_full, rd_valid, rd_skip;
  logic [15:0] rd_data;

  logic        n_wr_en = 1'b0, n_rd_en = 1'b0;
  logic [15:0] n_wr_data = '0;
  logic        n_wr_full, n_rd_valid, n_rd_skip;
  logic [15:0] n_rd_data;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  token_channel #(.DATA_W(16), .DEPTH(4), .INIT_TOKENS(1),
                  .INIT_VALUE(16'hA5A5), .BACKPRESSURE(1'b1)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_skip(rd_skip)
  );

  token_channel #(.DATA_W(16), .DEPTH(2), .INIT_TOKENS(0),
                  .INIT_VALUE(16'h0000), .BACKPRESSURE(1'b0)) dut_nbp (
    .clk(clk), .rst(rst), .wr_en(n_wr_en), .wr_data(n_wr_data), .wr_full(n_wr_full),
    .rd_en(n_rd_en), .rd_data(n_rd_data), .rd_valid(n_rd_valid), .rd_skip(n_rd_skip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle on the main instance; outputs sampled 1 ns after the edge
  task automatic cyc(input logic we, input logic [15:0] wd, input logic re);
    wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ncyc(input logic we, input logic [15:0] wd, input logic re);
    n_wr_en = we; n_wr_data = wd; n_rd_en = re;
    @(posedge clk); #1;
    n_wr_en = 1'b0; n_rd_en = 1'b0;
  endtask

  task automatic expect_tok(input string req, input logic [15:0] v);
    chk({req, " valid"}, rd_valid, 1'b1);
    chk({req, " skip"},  rd_skip,  1'b0);
    chk({req, " data"},  rd_data,  v);
  endtask

  task automatic expect_skip(input string req);
    chk({req, " valid"}, rd_valid, 1'b0);
    chk({req, " skip"},  rd_skip,  1'b1);
  endtask

  task automatic t_reset_init;
    chk("R1 reset valid", rd_valid, 1'b0);
    chk("R1 reset skip",  rd_skip,  1'b0);
    chk("R6 reset full",  wr_full,  1'b0);
    cyc(1'b0, '0, 1'b1);
    expect_tok("R1 init token", 16'hA5A5);
    cyc(1'b0, '0, 1'b1);
    expect_skip("R3 empty after init");
    cyc(1'b0, '0, 1'b0);
    chk("R5 idle valid", rd_valid, 1'b0);
    chk("R5 idle skip",  rd_skip,  1'b0);
  endtask

  task automatic t_same_cycle;
    cyc(1'b1, 16'h1111, 1'b1);
    expect_skip("R4 same-cycle write hidden");
    cyc(1'b0, '0, 1'b1);
    expect_tok("R4 visible next cycle", 16'h1111);
  endtask

  task automatic t_order;
    cyc(1'b1, 16'h0101, 1'b0);
    cyc(1'b1, 16'h0202, 1'b0);
    cyc(1'b1, 16'h0303, 1'b0);
    cyc(1'b0, '0, 1'b1); expect_tok("R2 order 1", 16'h0101);
    cyc(1'b0, '0, 1'b1); expect_tok("R2 order 2", 16'h0202);
    cyc(1'b0, '0, 1'b1); expect_tok("R2 order 3", 16'h0303);
    cyc(1'b0, '0, 1'b1); expect_skip("R3 drained");
  endtask

  task automatic t_full;
    cyc(1'b1, 16'h1000, 1'b0);
    cyc(1'b1, 16'h2000, 1'b0);
    cyc(1'b1, 16'h3000, 1'b0);
    chk("R6 not full at 3", wr_full, 1'b0);
    cyc(1'b1, 16'h4000, 1'b0);
    chk("R6 full at 4", wr_full, 1'b1);
    cyc(1'b1, 16'hDEAD, 1'b0);
    chk("R6 still full", wr_full, 1'b1);
    cyc(1'b0, '0, 1'b1);
    expect_tok("R6 oldest kept", 16'h1000);
    chk("R7 full cleared", wr_full, 1'b0);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 kept 2", 16'h2000);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 kept 3", 16'h3000);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 kept 4", 16'h4000);
    cyc(1'b0, '0, 1'b1); expect_skip("R6 dropped write absent");
  endtask

  task automatic t_full_rw;
    cyc(1'b1, 16'h0A0A, 1'b0);
    cyc(1'b1, 16'h0B0B, 1'b0);
    cyc(1'b1, 16'h0C0C, 1'b0);
    cyc(1'b1, 16'h0D0D, 1'b0);
    chk("R6 full before rw", wr_full, 1'b1);
    cyc(1'b1, 16'hBEEF, 1'b1);
    expect_tok("R6 read during full", 16'h0A0A);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 rw 2", 16'h0B0B);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 rw 3", 16'h0C0C);
    cyc(1'b0, '0, 1'b1); expect_tok("R6 rw 4", 16'h0D0D);
    cyc(1'b0, '0, 1'b1); expect_skip("R6 sampled-full write dropped");
  endtask

  task automatic t_overwrite;
    ncyc(1'b0, '0, 1'b1);
    chk("R8 empty start skip", n_rd_skip, 1'b1);
    ncyc(1'b1, 16'h0001, 1'b0);
    ncyc(1'b1, 16'h0002, 1'b0);
    chk("R8 no full flag", n_wr_full, 1'b0);
    ncyc(1'b1, 16'h0003, 1'b0);
    chk("R8 no full flag after lap", n_wr_full, 1'b0);
    ncyc(1'b0, '0, 1'b1);
    chk("R8 overwritten valid", n_rd_valid, 1'b1);
    chk("R8 overwritten data", n_rd_data, 16'h0003);
    ncyc(1'b0, '0, 1'b1);
    chk("R8 second slot data", n_rd_data, 16'h0002);
    ncyc(1'b0, '0, 1'b1);
    chk("R8 lost token skip", n_rd_skip, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_init();
    t_same_cycle();
    t_order();
    t_full();
    t_full_rw();
    t_overwrite();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule